// File: doc/BRIEF.md
# Banked External-Data Address Decoder

This block sits on the external-data (XDATA) bus of an embedded 8-bit microcontroller. Each request is classified into one of four regions, and the block forms the address that region expects. The low 16 KB goes to the chip's host register bus. On that path the upper address byte comes from the controller's port-2 bank register. A 1 KB window reaches a local scratch SRAM. A second 1 KB window can be steered onto a relocatable slice of code SRAM, and only while its enable input is high. Every other address falls through unchanged to an external memory bridge.

Requests arrive on a valid/ready channel. In the cycle a request is accepted, the block drives exactly one region chip select, the translated address for that region and the write strobe and data. The memories and the register bus live outside the block. They return read data in the cycle after their select. The block multiplexes that data onto a one-deep valid/ready response channel.

Back-pressure works as follows. A read response is presented in the cycle after its request is accepted, and it stays valid, with data unchanged, until `rsp_ready` is high at a clock edge. While a response is waiting and `rsp_ready` is low, `req_ready` is low and no new request is taken. Writes produce no response.

Top module: `xdata_bank_decoder`

## Requirements
- R1: An accepted address in 0x0000–0x3FFF asserts `reg_cs`. `reg_addr` is {`port2_bank`, address[13:0]}, with the bank in bits 21:14.
- R2: An accepted address in 0x4000–0x43FF asserts `sram_cs`, with `sram_addr` = address[9:0].
- R3: While `code_view_en` is 1, an accepted address in 0x5000–0x53FF asserts `code_cs`. `code_addr` is {`code_view_base`, address[9:0]}, with the base in bits 17:10.
- R4: While `code_view_en` is 0, addresses 0x5000–0x53FF assert `bridge_cs` instead, and `code_cs` stays 0.
- R5: Every other address asserts `bridge_cs`, with `bridge_addr` equal to the untranslated 16-bit address. This includes the gaps 0x4400–0x4FFF and 0x5400–0xFFFF.
- R6: In a cycle where `req_valid && req_ready`, exactly one of the four chip selects is 1. In any other cycle all four are 0.
- R7: After a read (`req_we`=0) is accepted, `rsp_valid` is 1 in the next cycle. `rsp_rdata` then equals the read data input of the selected region in that cycle.
- R8: `req_ready` is 1 exactly when `rsp_valid` is 0 or `rsp_ready` is 1. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_rdata` hold, even if region read data changes.
- R9: An accepted write drives `acc_we`=1 and `acc_wdata`=`req_wdata` with the region select. No response follows.
- R10: While `rst_n` is low, and in the first cycle after reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 16 | XDATA address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| port2_bank | input | 8 | Port-2 bank byte for register-bus accesses |
| code_view_en | input | 1 | Enables the code-SRAM window |
| code_view_base | input | 8 | Code SRAM address bits 17:10 for the window |
| reg_cs | output | 1 | Register-bus select |
| reg_addr | output | 22 | Register-bus address |
| sram_cs | output | 1 | Local SRAM select |
| sram_addr | output | 10 | Local SRAM address |
| code_cs | output | 1 | Code SRAM select |
| code_addr | output | 18 | Code SRAM address |
| bridge_cs | output | 1 | Memory-bridge select |
| bridge_addr | output | 16 | Memory-bridge address |
| acc_we | output | 1 | Write strobe to the selected region |
| acc_wdata | output | 8 | Write data to the selected region |
| reg_rdata | input | 8 | Register-bus read data, cycle after select |
| sram_rdata | input | 8 | SRAM read data, cycle after select |
| code_rdata | input | 8 | Code SRAM read data, cycle after select |
| bridge_rdata | input | 8 | Bridge read data, cycle after select |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 8 | Read response data |

## Verification
A wrong region decode shows in the same cycle as the request, as a wrong or doubled chip select or a misformed address. A stale stored region shows one cycle later, as response data taken from the wrong region's input. A corrupt response valid or hold register shows as a lost, duplicated or changing response during a stall. It also shows as `req_ready` disagreeing with the response state on the very next edge. The sweep therefore checks select and address combinationally at every address, then checks the response one cycle later.

// File: rtl/xdec_pkg.sv
`timescale 1ns/1ps
package xdec_pkg;

  typedef enum logic [1:0] {
    RGN_REG    = 2'd0,
    RGN_SRAM   = 2'd1,
    RGN_CODE   = 2'd2,
    RGN_BRIDGE = 2'd3
  } xdec_rgn_e;

  localparam int unsigned NUM_RGN = 4;

endpackage

// File: rtl/xdec_region_decode.sv
`timescale 1ns/1ps
module xdec_region_decode
  import xdec_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned REG_WIN_BITS = 14,
  parameter int unsigned WIN_BITS     = 10,
  parameter int unsigned SRAM_BASE    = 'h4000,
  parameter int unsigned CODE_BASE    = 'h5000
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               view_en,
  input  logic               accept,
  output xdec_rgn_e          rgn,
  output logic [NUM_RGN-1:0] sel
);

  localparam int unsigned TAG_W = ADDR_W - WIN_BITS;
  localparam int unsigned HI_W  = ADDR_W - REG_WIN_BITS;
  localparam logic [ADDR_W-1:0] SRAM_BASE_V = ADDR_W'(SRAM_BASE);
  localparam logic [ADDR_W-1:0] CODE_BASE_V = ADDR_W'(CODE_BASE);
  localparam logic [TAG_W-1:0]  SRAM_TAG    = SRAM_BASE_V[ADDR_W-1:WIN_BITS];
  localparam logic [TAG_W-1:0]  CODE_TAG    = CODE_BASE_V[ADDR_W-1:WIN_BITS];

  logic hit_reg, hit_sram, hit_code;

  always_comb begin
    hit_reg  = (addr[ADDR_W-1:REG_WIN_BITS] == {HI_W{1'b0}});
    hit_sram = (addr[ADDR_W-1:WIN_BITS] == SRAM_TAG);
    hit_code = (addr[ADDR_W-1:WIN_BITS] == CODE_TAG) && view_en;
  end

  // Fixed priority; the windows do not overlap with the defaults.
  always_comb begin
    if (hit_reg)       rgn = RGN_REG;
    else if (hit_sram) rgn = RGN_SRAM;
    else if (hit_code) rgn = RGN_CODE;
    else               rgn = RGN_BRIDGE;
  end

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_sel
    assign sel[g] = accept && (rgn == xdec_rgn_e'(g));
  end

endmodule

// File: rtl/xdec_addr_xlate.sv
`timescale 1ns/1ps
module xdec_addr_xlate #(
  parameter int unsigned REG_WIN_BITS = 14,
  parameter int unsigned WIN_BITS     = 10,
  parameter int unsigned BANK_W       = 8,
  parameter int unsigned BASE_W       = 8
) (
  input  logic [REG_WIN_BITS-1:0]        addr_lo,
  input  logic [BANK_W-1:0]              bank,
  input  logic [BASE_W-1:0]              view_base,
  output logic [BANK_W+REG_WIN_BITS-1:0] reg_addr,
  output logic [WIN_BITS-1:0]            sram_addr,
  output logic [BASE_W+WIN_BITS-1:0]     code_addr
);

  always_comb begin
    reg_addr  = {bank, addr_lo};
    sram_addr = addr_lo[WIN_BITS-1:0];
    code_addr = {view_base, addr_lo[WIN_BITS-1:0]};
  end

endmodule

// File: rtl/xdec_resp_stage.sv
`timescale 1ns/1ps
module xdec_resp_stage
  import xdec_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_accept,
  input  xdec_rgn_e         rgn_in,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] sram_rdata,
  input  logic [DATA_W-1:0] code_rdata,
  input  logic [DATA_W-1:0] bridge_rdata,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  xdec_rgn_e         rgn_q;
  logic              fresh_q;
  logic              valid_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] mux_data;

  always_comb begin
    unique case (rgn_q)
      RGN_REG:  mux_data = reg_rdata;
      RGN_SRAM: mux_data = sram_rdata;
      RGN_CODE: mux_data = code_rdata;
      default:  mux_data = bridge_rdata;
    endcase
  end

  // First response cycle passes region data; later stall cycles replay it.
  assign rsp_rdata = fresh_q ? mux_data : hold_q;
  assign rsp_valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgn_q   <= RGN_BRIDGE;
      fresh_q <= 1'b0;
      valid_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      fresh_q <= rd_accept;
      if (rd_accept) rgn_q <= rgn_in;
      if (valid_q)   hold_q <= rsp_rdata;
      if (rd_accept)      valid_q <= 1'b1;
      else if (rsp_ready) valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/xdata_bank_decoder.sv
`timescale 1ns/1ps
module xdata_bank_decoder
  import xdec_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned BANK_W       = 8,
  parameter int unsigned BASE_W       = 8,
  parameter int unsigned REG_WIN_BITS = 14,
  parameter int unsigned WIN_BITS     = 10,
  parameter int unsigned SRAM_BASE    = 'h4000,
  parameter int unsigned CODE_BASE    = 'h5000,
  localparam int unsigned REG_AW      = BANK_W + REG_WIN_BITS,
  localparam int unsigned CODE_AW     = BASE_W + WIN_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_we,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [BANK_W-1:0]   port2_bank,
  input  logic                code_view_en,
  input  logic [BASE_W-1:0]   code_view_base,
  output logic                reg_cs,
  output logic [REG_AW-1:0]   reg_addr,
  output logic                sram_cs,
  output logic [WIN_BITS-1:0] sram_addr,
  output logic                code_cs,
  output logic [CODE_AW-1:0]  code_addr,
  output logic                bridge_cs,
  output logic [ADDR_W-1:0]   bridge_addr,
  output logic                acc_we,
  output logic [DATA_W-1:0]   acc_wdata,
  input  logic [DATA_W-1:0]   reg_rdata,
  input  logic [DATA_W-1:0]   sram_rdata,
  input  logic [DATA_W-1:0]   code_rdata,
  input  logic [DATA_W-1:0]   bridge_rdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata
);

  logic               accept;
  xdec_rgn_e          rgn;
  logic [NUM_RGN-1:0] sel;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  xdec_region_decode #(
    .ADDR_W(ADDR_W), .REG_WIN_BITS(REG_WIN_BITS), .WIN_BITS(WIN_BITS),
    .SRAM_BASE(SRAM_BASE), .CODE_BASE(CODE_BASE)
  ) u_decode (
    .addr(req_addr), .view_en(code_view_en), .accept(accept),
    .rgn(rgn), .sel(sel)
  );

  xdec_addr_xlate #(
    .REG_WIN_BITS(REG_WIN_BITS), .WIN_BITS(WIN_BITS),
    .BANK_W(BANK_W), .BASE_W(BASE_W)
  ) u_xlate (
    .addr_lo(req_addr[REG_WIN_BITS-1:0]), .bank(port2_bank),
    .view_base(code_view_base), .reg_addr(reg_addr),
    .sram_addr(sram_addr), .code_addr(code_addr)
  );

  xdec_resp_stage #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .rd_accept(accept && !req_we), .rgn_in(rgn),
    .reg_rdata(reg_rdata), .sram_rdata(sram_rdata), .code_rdata(code_rdata),
    .bridge_rdata(bridge_rdata), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign reg_cs      = sel[RGN_REG];
  assign sram_cs     = sel[RGN_SRAM];
  assign code_cs     = sel[RGN_CODE];
  assign bridge_cs   = sel[RGN_BRIDGE];
  assign bridge_addr = req_addr;
  assign acc_we      = accept && req_we;
  assign acc_wdata   = req_wdata;

endmodule

// File: rtl/xdata_bank_decoder_chk.sv
`timescale 1ns/1ps
module xdata_bank_decoder_chk #(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned REG_AW = 22,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic [BANK_W-1:0] port2_bank,
  input logic              code_view_en,
  input logic              reg_cs,
  input logic [REG_AW-1:0] reg_addr,
  input logic              sram_cs,
  input logic              code_cs,
  input logic              bridge_cs,
  input logic [DATA_W-1:0] sram_rdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata
);

  logic acc;
  logic [3:0] cs_vec;
  assign acc    = req_valid && req_ready;
  assign cs_vec = {bridge_cs, code_cs, sram_cs, reg_cs};

  AST_BANK_IN_REG_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_cs |-> reg_addr[REG_AW-1:REG_AW-BANK_W] == port2_bank); // R1
  AST_CODE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    code_cs |-> code_view_en); // R3
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> $countones(cs_vec) == 1); // R6
  AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> cs_vec == 4'b0); // R6
  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_we |=> rsp_valid); // R7
  AST_SRAM_DATA_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs && !req_we |=> rsp_rdata == sram_rdata); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R8
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_we |=> !rsp_valid); // R9

endmodule

bind xdata_bank_decoder xdata_bank_decoder_chk #(
  .BANK_W(BANK_W), .REG_AW(REG_AW), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/xdata_bank_decoder_tb_top.sv
`timescale 1ns/1ps
module xdata_bank_decoder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, code_view_en = 1'b0, rsp_ready = 1'b1;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, port2_bank = '0, code_view_base = '0;
  logic [7:0]  reg_rdata = '0, sram_rdata = '0, code_rdata = '0, bridge_rdata = '0;
  logic req_ready, reg_cs, sram_cs, code_cs, bridge_cs, acc_we, rsp_valid;
  logic [21:0] reg_addr;
  logic [9:0]  sram_addr;
  logic [17:0] code_addr;
  logic [15:0] bridge_addr;
  logic [7:0]  acc_wdata, rsp_rdata;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xdata_bank_decoder dut_i (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One read through the sweep: selects and address in the request cycle,
  // response data one cycle later.
  task automatic do_read(input logic [15:0] a, input logic en);
    logic [3:0]  exp_sel;
    logic [31:0] exp_addr, act_addr;
    logic [7:0]  exp_data;
    string       tag;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a; code_view_en = en;
    port2_bank = a[15:8] + 8'h3C; code_view_base = ~a[7:0];
    #1;
    if (a < 16'h4000) begin
      exp_sel = 4'b0001; tag = "R1";
      exp_addr = {10'd0, port2_bank, a[13:0]}; act_addr = {10'd0, reg_addr};
      exp_data = a[7:0] ^ 8'h11;
    end else if (a < 16'h4400) begin
      exp_sel = 4'b0010; tag = "R2";
      exp_addr = {22'd0, a[9:0]}; act_addr = {22'd0, sram_addr};
      exp_data = a[7:0] ^ 8'h22;
    end else if (en && a >= 16'h5000 && a < 16'h5400) begin
      exp_sel = 4'b0100; tag = "R3";
      exp_addr = {14'd0, code_view_base, a[9:0]}; act_addr = {14'd0, code_addr};
      exp_data = a[7:0] ^ 8'h33;
    end else begin
      exp_sel = 4'b1000;
      tag = (a >= 16'h5000 && a < 16'h5400) ? "R4" : "R5";
      exp_addr = {16'd0, a}; act_addr = {16'd0, bridge_addr};
      exp_data = a[7:0] ^ 8'h44;
    end
    chk({bridge_cs, code_cs, sram_cs, reg_cs} == exp_sel, {tag, "/R6 select"},
        {28'd0, bridge_cs, code_cs, sram_cs, reg_cs}, {28'd0, exp_sel});
    chk(act_addr == exp_addr, {tag, " address"}, act_addr, exp_addr);
    @(negedge clk);
    req_valid = 1'b0;
    reg_rdata = a[7:0] ^ 8'h11; sram_rdata = a[7:0] ^ 8'h22;
    code_rdata = a[7:0] ^ 8'h33; bridge_rdata = a[7:0] ^ 8'h44;
    #1;
    chk(rsp_valid == 1'b1 && rsp_rdata == exp_data, "R7 response",
        {23'd0, rsp_valid, rsp_rdata}, {23'd1, exp_data});
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 in reset",
        {30'd0, rsp_valid, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 after reset",
        {30'd0, rsp_valid, req_ready}, 32'd1);
    chk({bridge_cs, code_cs, sram_cs, reg_cs} == 4'b0, "R6 idle",
        {28'd0, bridge_cs, code_cs, sram_cs, reg_cs}, 32'd0);

    // Full address sweep with the code view enabled (R1, R2, R3, R5).
    for (int a = 0; a < 65536; a++) do_read(a[15:0], 1'b1);
    // Window region again with the view disabled (R4 and gaps for R5).
    for (int a = 16'h4000; a < 16'h6000; a++) do_read(a[15:0], 1'b0);

    // Back-pressure: response held, requests blocked (R8).
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 16'h4005;
    @(negedge clk);
    req_valid = 1'b0; rsp_ready = 1'b0; sram_rdata = 8'hC3;
    #1;
    chk(rsp_valid && rsp_rdata == 8'hC3, "R7 stalled first", {24'd0, rsp_rdata}, 32'hC3);
    chk(req_ready == 1'b0, "R8 ready low", {31'd0, req_ready}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      sram_rdata = 8'h10 + 8'(k);
      req_valid = 1'b1; req_addr = 16'h0100;
      #1;
      chk(rsp_valid && rsp_rdata == 8'hC3, "R8 hold", {23'd0, rsp_valid, rsp_rdata},
          {23'd1, 8'hC3});
      chk({bridge_cs, code_cs, sram_cs, reg_cs} == 4'b0, "R8/R6 no accept",
          {28'd0, bridge_cs, code_cs, sram_cs, reg_cs}, 32'd0);
    end
    req_valid = 1'b0;
    @(negedge clk);
    rsp_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R8 ready returns", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 drained", {31'd0, rsp_valid}, 32'd0);

    // Write: strobe and data, no response (R9).
    req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h4010; req_wdata = 8'h5A;
    #1;
    chk(sram_cs && acc_we && acc_wdata == 8'h5A, "R9 write strobe",
        {22'd0, sram_cs, acc_we, acc_wdata}, {22'd0, 2'b11, 8'h5A});
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    #1;
    chk(rsp_valid == 1'b0 && acc_we == 1'b0, "R9 no response",
        {30'd0, rsp_valid, acc_we}, 32'd0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule